// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block is a synchronous controller for an asynchronous fast-page-mode DRAM. A host presents single read or write requests through a valid/ready handshake. The controller converts each request into a timed sequence of active-low row strobe, column strobe, write enable and output enable. It places the row half and then the column half of the address on a shared multiplexed address bus. Every DRAM timing limit is a clock-cycle count set by a parameter.

The controller owns the DRAM from reset onwards. It first holds all strobes inactive through a power-up pause, whose length is derived from the clock frequency. It then runs a burst of column-before-row refresh cycles and only after that offers ready to the host. During normal traffic an internal interval counter raises a refresh demand. That demand wins over any waiting host request at the next idle point, but it never cuts short a cycle already in flight.

Writes are early writes: write enable is low before the column strobe falls, and output enable stays high. Reads return data with a one-cycle valid pulse.

Top module: `fpm_ctrl`

## Requirements
- R1: After reset, all four strobes stay high and `req_ready` stays low for at least PAUSE_CYC = CLK_KHZ*PAUSE_US/1000 cycles (40000 at defaults).
- R2: After the pause, exactly INIT_REFS (8) refresh cycles complete before `req_ready` is high for the first time; a request held valid during that time is accepted only afterwards.
- R3: The gap between the row-strobe falls of consecutive refresh cycles never exceeds REF_CYC = CLK_KHZ*REFI_NS/1e6 cycles (3120 at defaults), whether the host is busy or idle.
- R4: In a refresh cycle the column strobe falls at least T_CSR cycles before the row strobe, write enable stays high, and the address bus is not used.
- R5: In an access, the row strobe falls with the row on `dram_addr`, and the column strobe falls exactly T_RCD cycles later with the column on `dram_addr`. The row is `req_addr[ROW_W+COL_W-1:COL_W]` and the column is `req_addr[COL_W-1:0]`.
- R6: A write lowers write enable at least one cycle before the column strobe falls, drives `req_wdata` on `dram_dq_out` with `dram_dq_oe` high, and keeps `dram_oe_n` high for the whole cycle.
- R7: A read lowers `dram_oe_n`, samples `dram_dq_in` after the column strobe has been low for at least T_CAC cycles, and returns that value on `rd_data` with `rd_valid` high for exactly one cycle.
- R8: Every low pulse of the row strobe lasts at least T_RAS cycles, and every low pulse of the column strobe lasts at least T_CAS cycles.
- R9: Before any row-strobe fall of an access, and before any column-strobe fall of a refresh, both strobes have been high for at least T_RP cycles.
- R10: A due refresh is issued ahead of a waiting host request. `req_ready` is low while the refresh runs, and the refresh never starts inside an access.
- R11: A request is taken on a cycle where `req_valid` and `req_ready` are both high. Requests complete in acceptance order, and each read yields exactly one `rd_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address, row in upper bits |
| req_wdata | input | DQ_W | Write data |
| rd_valid | output | 1 | One-cycle read data valid |
| rd_data | output | DQ_W | Read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_dq_out | output | DQ_W | Data toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | DQ_W | Data from the DRAM |

## Verification
The hardest case to reach from the ports is a refresh demand that matures while a host request is already waiting. In that case the controller must choose the refresh without breaking the access in progress and without letting the request starve the refresh. The stimulus reaches this case by keeping `req_valid` high back-to-back across several refresh intervals, and also by mixing random idle gaps, so that the demand lands at many phases of an access. The DRAM model counts how often a refresh began while a request was pending, and it checks every refresh gap.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  typedef enum logic [2:0] {
    ST_PAUSE, ST_IDLE, ST_ROW, ST_RAS, ST_CAS, ST_PRE, ST_RCAS, ST_RRAS
  } fpm_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/fpm_timer.sv
module fpm_timer #(
  parameter int W       = 16,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= W'(RST_VAL);
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/fpm_refresh_sched.sv
module fpm_refresh_sched #(
  parameter int PERIOD = 3056
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic ack,
  output logic due
);
  localparam int CW = $clog2(PERIOD + 1);
  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = (cnt == CW'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
      due <= 1'b0;
    end else begin
      cnt <= wrap ? '0 : cnt + 1'b1;
      if (wrap)     due <= 1'b1;
      else if (ack) due <= 1'b0;
    end
  end

  // R3: a demand is held until it is served
  p_due_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (due && !ack) |=> due);
  // R10: the top only acknowledges a demand that exists
  p_ack_due_r10: assert property (@(posedge clk) disable iff (rst)
    ack |-> due);
endmodule

// File: rtl/fpm_ctrl.sv
module fpm_ctrl
  import fpm_pkg::*;
#(
  parameter int CLK_KHZ   = 200000,
  parameter int PAUSE_US  = 200,
  parameter int REFI_NS   = 15600,
  parameter int REF_SLACK = 64,
  parameter int INIT_REFS = 8,
  parameter int ROW_W     = 11,
  parameter int COL_W     = 11,
  parameter int DQ_W      = 4,
  parameter int T_RCD     = 3,
  parameter int T_CAC     = 3,
  parameter int T_CAS     = 3,
  parameter int T_RAS     = 12,
  parameter int T_RP      = 8,
  parameter int T_CSR     = 2,
  localparam int ADDR_W   = ROW_W + COL_W,
  localparam int MA_W     = imax(ROW_W, COL_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DQ_W-1:0]   req_wdata,
  output logic              rd_valid,
  output logic [DQ_W-1:0]   rd_data,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [MA_W-1:0]   dram_addr,
  output logic [DQ_W-1:0]   dram_dq_out,
  output logic              dram_dq_oe,
  input  logic [DQ_W-1:0]   dram_dq_in
);
  localparam int PAUSE_CYC  = CLK_KHZ * PAUSE_US / 1000;
  localparam int REF_CYC    = (CLK_KHZ / 1000) * REFI_NS / 1000;
  localparam int REF_PERIOD = REF_CYC - REF_SLACK;
  localparam int CAS_HOLD   = imax(imax(T_CAS, T_CAC), T_RAS - T_RCD);
  localparam int TW         = $clog2(imax(PAUSE_CYC, imax(CAS_HOLD, imax(T_RAS, T_RP))) + 1);
  localparam int IW         = $clog2(INIT_REFS + 1);

  fpm_state_e        state, nxt;
  logic              t_load, t_done;
  logic [TW-1:0]     t_val;
  logic [IW-1:0]     init_cnt;
  logic              init_done, ref_due, ref_ack, accept, rd_done, go_ref;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [DQ_W-1:0]   wd_q;
  logic              wr_q;

  fpm_timer #(.W(TW), .RST_VAL(PAUSE_CYC - 1)) u_timer (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .done(t_done));

  fpm_refresh_sched #(.PERIOD(REF_PERIOD)) u_sched (
    .clk(clk), .rst(rst), .en(init_done), .ack(ref_ack), .due(ref_due));

  assign init_done = (init_cnt == IW'(INIT_REFS));
  assign req_ready = (state == ST_IDLE) && init_done && !ref_due;

  always_comb begin
    nxt    = state;
    t_load = 1'b0;
    t_val  = '0;
    unique case (state)
      ST_PAUSE: if (t_done) nxt = ST_IDLE;
      ST_IDLE: begin
        if (!init_done || ref_due) begin
          nxt = ST_RCAS; t_load = 1'b1; t_val = TW'(T_CSR - 1);
        end else if (req_valid) begin
          nxt = ST_ROW; t_load = 1'b1; t_val = '0;
        end
      end
      ST_ROW:  if (t_done) begin nxt = ST_RAS;  t_load = 1'b1; t_val = TW'(T_RCD - 1);    end
      ST_RAS:  if (t_done) begin nxt = ST_CAS;  t_load = 1'b1; t_val = TW'(CAS_HOLD - 1); end
      ST_CAS:  if (t_done) begin nxt = ST_PRE;  t_load = 1'b1; t_val = TW'(T_RP - 1);     end
      ST_RCAS: if (t_done) begin nxt = ST_RRAS; t_load = 1'b1; t_val = TW'(T_RAS - 1);    end
      ST_RRAS: if (t_done) begin nxt = ST_PRE;  t_load = 1'b1; t_val = TW'(T_RP - 1);     end
      ST_PRE:  if (t_done) nxt = ST_IDLE;
      default: nxt = ST_PAUSE;
    endcase
  end

  assign go_ref  = (state == ST_IDLE) && (nxt == ST_RCAS);
  assign ref_ack = go_ref && init_done;
  assign accept  = (state == ST_IDLE) && (nxt == ST_ROW);
  assign rd_done = (state == ST_CAS) && (nxt == ST_PRE) && !wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_PAUSE;
      init_cnt    <= '0;
      row_q       <= '0;
      col_q       <= '0;
      wd_q        <= '0;
      wr_q        <= 1'b0;
      dram_ras_n  <= 1'b1;
      dram_cas_n  <= 1'b1;
      dram_we_n   <= 1'b1;
      dram_oe_n   <= 1'b1;
      dram_dq_oe  <= 1'b0;
      dram_dq_out <= '0;
      dram_addr   <= '0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
    end else begin
      state <= nxt;
      if (go_ref && !init_done) init_cnt <= init_cnt + 1'b1;
      if (accept) begin
        row_q <= req_addr[ADDR_W-1:COL_W];
        col_q <= req_addr[COL_W-1:0];
        wd_q  <= req_wdata;
        wr_q  <= req_write;
      end
      dram_ras_n  <= !(nxt inside {ST_RAS, ST_CAS, ST_RRAS});
      dram_cas_n  <= !(nxt inside {ST_CAS, ST_RCAS, ST_RRAS});
      dram_we_n   <= !(wr_q && (nxt inside {ST_RAS, ST_CAS}));
      dram_oe_n   <= !(!wr_q && (nxt == ST_CAS));
      dram_dq_oe  <= wr_q && (nxt inside {ST_RAS, ST_CAS});
      dram_dq_out <= wd_q;
      if (nxt == ST_CAS)  dram_addr <= MA_W'(col_q);
      else if (accept)    dram_addr <= MA_W'(req_addr[ADDR_W-1:COL_W]);
      else                dram_addr <= MA_W'(row_q);
      rd_valid <= rd_done;
      if (rd_done) rd_data <= dram_dq_in;
    end
  end

  // Pulse-width observers for the assertions below
  logic [TW-1:0] ras_lo_cnt, cas_lo_cnt, pre_cnt;
  always_ff @(posedge clk) begin
    if (rst) begin
      ras_lo_cnt <= '0; cas_lo_cnt <= '0; pre_cnt <= '0;
    end else begin
      ras_lo_cnt <= dram_ras_n ? '0 : ((ras_lo_cnt == '1) ? ras_lo_cnt : ras_lo_cnt + 1'b1);
      cas_lo_cnt <= dram_cas_n ? '0 : ((cas_lo_cnt == '1) ? cas_lo_cnt : cas_lo_cnt + 1'b1);
      pre_cnt    <= (dram_ras_n && dram_cas_n) ?
                    ((pre_cnt == '1) ? pre_cnt : pre_cnt + 1'b1) : '0;
    end
  end

  p_pause_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PAUSE) |-> (dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n && !req_ready));
  p_cbr_order_r4: assert property (@(posedge clk) disable iff (rst)
    ($fell(dram_ras_n) && !dram_cas_n) |-> ($past(!dram_cas_n) && dram_we_n));
  p_early_write_r6: assert property (@(posedge clk) disable iff (rst)
    ($fell(dram_cas_n) && !dram_we_n) |-> ($past(!dram_we_n) && dram_oe_n && dram_dq_oe));
  p_ras_width_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(dram_ras_n) |-> (ras_lo_cnt >= TW'(T_RAS)));
  p_cas_width_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(dram_cas_n) |-> (cas_lo_cnt >= TW'(T_CAS)));
  p_precharge_r9: assert property (@(posedge clk) disable iff (rst)
    (($fell(dram_ras_n) && dram_cas_n) || ($fell(dram_cas_n) && dram_ras_n))
      |-> (pre_cnt >= TW'(T_RP)));
  p_rd_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
endmodule

// File: tb/sim_fpm_ctrl.sv
`timescale 1ns/1ps
module sim_fpm_ctrl;
  localparam int PAUSE_CYC = 40000;
  localparam int REF_CYC   = 3120;
  localparam int INIT_REFS = 8;
  localparam int T_RCD = 3, T_CAC = 3, T_CAS = 3, T_RAS = 12, T_RP = 8, T_CSR = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [21:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic req_ready, rd_valid, ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [3:0]  rd_data, dq_out;
  logic [3:0]  dq_in = '0;
  logic [10:0] maddr;

  always #2.5 clk = ~clk;

  fpm_ctrl u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .dram_ras_n(ras_n), .dram_cas_n(cas_n),
    .dram_we_n(we_n), .dram_oe_n(oe_n), .dram_addr(maddr), .dram_dq_out(dq_out),
    .dram_dq_oe(dq_oe), .dram_dq_in(dq_in));

  int total = 0, bad = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [21:0] mk_addr(input logic [7:0] k);
    return {{7{k[7]}}, k[7:4], {7{k[3]}}, k[3:0]};
  endfunction

  logic [3:0]  ref_mem  [256];
  logic [3:0]  dram_mem [256];
  logic [21:0] acc_addr_q [$];
  logic        acc_wr_q   [$];
  logic [3:0]  rd_exp_q   [$];

  // DRAM model and port monitor, evaluated away from the active edge
  int cyc = 0, nref = 0, last_ref = -1, ras_len = 0, cas_len = 0, hi_len = 0;
  int contended = 0, first_act = -1;
  bit p_ras = 1, p_cas = 1, p_we = 1, p_rdv = 0, cur_wr = 0, seen_ready = 0, in_ref = 0;
  bit pause_ok = 1, ready_ref_ok = 1;
  logic [10:0] m_row = '0, m_col = '0;
  logic [21:0] cur_addr = '0;

  always @(posedge clk) if (!rst) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (cyc <= PAUSE_CYC && (!ras_n || !cas_n || !we_n || !oe_n || req_ready)) pause_ok = 0;
      if (first_act < 0 && (!ras_n || !cas_n)) begin
        first_act = cyc;
        check(pause_ok && cyc > PAUSE_CYC, "R1 quiet pause", cyc, PAUSE_CYC + 1);
      end
      if (req_ready && !seen_ready) begin
        seen_ready = 1;
        check(nref == INIT_REFS, "R2 refreshes before first ready", nref, INIT_REFS);
      end
      if (in_ref && req_ready) ready_ref_ok = 0;
      // refresh start: column strobe first
      if (p_cas && !cas_n && ras_n) begin
        in_ref = 1;
        check(hi_len >= T_RP, "R9 precharge before refresh", hi_len, T_RP);
        check(we_n, "R4 write enable high in refresh", we_n, 1);
        if (req_valid && seen_ready) contended++;
      end
      if (p_ras && !ras_n && !cas_n) begin
        check(cas_len >= T_CSR, "R4 column before row", cas_len, T_CSR);
        if (last_ref >= 0)
          check(cyc - last_ref <= REF_CYC, "R3 refresh gap", cyc - last_ref, REF_CYC);
        last_ref = cyc;
        nref++;
      end
      if (p_ras && !ras_n && cas_n) begin
        check(hi_len >= T_RP, "R9 precharge before access", hi_len, T_RP);
        check(acc_addr_q.size() > 0, "R11 access without request", 0, 1);
        if (acc_addr_q.size() > 0) begin
          cur_addr = acc_addr_q.pop_front();
          cur_wr   = acc_wr_q.pop_front();
        end
        m_row = maddr;
        check(maddr == cur_addr[21:11], "R5 row address", maddr, cur_addr[21:11]);
      end
      if (p_cas && !cas_n && !ras_n) begin
        m_col = maddr;
        check(ras_len == T_RCD, "R5 row-to-column delay", ras_len, T_RCD);
        check(maddr == cur_addr[10:0], "R5 column address", maddr, cur_addr[10:0]);
        if (cur_wr) begin
          check(!we_n && !p_we && oe_n && dq_oe, "R6 early write strobes",
                {we_n, p_we, oe_n, dq_oe}, 4'b0011);
          dram_mem[{m_row[3:0], m_col[3:0]}] = dq_out;
        end else begin
          check(we_n && !oe_n, "R7 read strobes", {we_n, oe_n}, 2'b10);
        end
      end
      if (!p_ras && ras_n) check(ras_len >= T_RAS, "R8 row strobe width", ras_len, T_RAS);
      if (!p_cas && cas_n) begin
        check(cas_len >= T_CAS, "R8 column strobe width", cas_len, T_CAS);
        if (in_ref) in_ref = 0;
      end
      if (rd_valid) begin
        check(!p_rdv, "R7 read valid single pulse", p_rdv, 0);
        check(rd_exp_q.size() > 0, "R11 unexpected read data", 0, 1);
        if (rd_exp_q.size() > 0) begin
          logic [3:0] e;
          e = rd_exp_q.pop_front();
          check(rd_data == e, "R7 read data", rd_data, e);
        end
      end
      ras_len = ras_n ? 0 : ras_len + 1;
      cas_len = cas_n ? 0 : cas_len + 1;
      hi_len  = (ras_n && cas_n) ? hi_len + 1 : 0;
      p_ras = ras_n; p_cas = cas_n; p_we = we_n; p_rdv = rd_valid;
      dq_in = (!ras_n && !cas_n && !oe_n && cas_len >= T_CAC) ?
              dram_mem[{m_row[3:0], m_col[3:0]}] : ~dram_mem[{m_row[3:0], m_col[3:0]}];
    end
  end

  task automatic issue(input bit wr, input logic [7:0] k, input logic [3:0] d);
    req_valid = 1'b1; req_write = wr; req_addr = mk_addr(k); req_wdata = d;
    while (!req_ready) @(negedge clk);
    acc_addr_q.push_back(mk_addr(k));
    acc_wr_q.push_back(wr);
    if (wr) ref_mem[k] = d;
    else    rd_exp_q.push_back(ref_mem[k]);
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin ref_mem[i] = '0; dram_mem[i] = '0; end
    void'($urandom(32'd24681));
    repeat (5) @(negedge clk);
    check(ras_n && cas_n && we_n && oe_n && !req_ready && !rd_valid, "R1 reset state",
          {ras_n, cas_n, we_n, oe_n, req_ready, rd_valid}, 6'b111100);
    rst = 1'b0;
    // R2: request waiting through the pause and init refreshes
    issue(1'b1, 8'hFF, 4'hA);
    issue(1'b0, 8'hFF, 4'h0);
    issue(1'b1, 8'h00, 4'h5);
    issue(1'b0, 8'h00, 4'h0);
    issue(1'b0, 8'h3C, 4'h0);
    req_valid = 1'b0;
    // random mix with idle gaps (R5..R9, R11)
    for (int i = 0; i < 500; i++) begin
      issue(1'($urandom % 2), 8'($urandom % 256), 4'($urandom));
      if ($urandom % 4 == 0) begin
        req_valid = 1'b0;
        repeat ($urandom % 30) @(negedge clk);
      end
    end
    // back-to-back reads keep a request pending at every refresh (R10)
    for (int i = 0; i < 300; i++) issue(1'b0, 8'($urandom % 256), 4'h0);
    req_valid = 1'b0;
    // idle: refresh must keep running (R3)
    repeat (2 * REF_CYC + 100) @(negedge clk);
    check(cyc - last_ref <= REF_CYC, "R3 refresh while idle", cyc - last_ref, REF_CYC);
    check(contended > 0, "R10 refresh chosen over waiting request", contended, 1);
    check(ready_ref_ok, "R10 ready low during refresh", ready_ref_ok, 1);
    check(acc_addr_q.size() == 0 && rd_exp_q.size() == 0, "R11 all requests completed",
          acc_addr_q.size() + rd_exp_q.size(), 0);
    summary();
  end

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    summary();
  end
endmodule